// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block handles in-band software flow control for one serial channel. It sits between the receive deserializer and the receive FIFO, and between the transmit FIFO and the transmit shifter. Every received character is compared against two programmable control characters, a resume code and a pause code. A match can stop or restart the local transmitter, and it can be removed from the data written to the receive FIFO. It is also logged in a status byte that the host clears by reading it.

On the transmit side the block raises its own pause or resume requests. A pause code is requested when the receive FIFO level climbs to a high mark. A resume code is requested when the level falls to a low mark. The host can also queue either code with a command pulse. A queued control code is handed to the shifter before the next FIFO character, but only while the shifter is idle. A character already being shifted out is never cut short. The receive-side reaction and the transmit-side throttling are enabled separately.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: A hardware reset or a `sw_reset` pulse returns the resume code to 0x11 and the pause code to 0x13, and clears the pause flag, the throttle state, both pending requests and all status bits.
- R2: A pulse on `on_char_we` or `off_char_we` loads `cfg_char` as the new resume or pause code. Recognition uses the new value from the next cycle on, and the old value is no longer recognized.
- R3: When `cfg_strip` is 0, every received character is forwarded on `rx_push` in the same cycle with unchanged data. When `cfg_strip` is 1, a recognized control character is not forwarded, and other characters still are.
- R4: With `cfg_auto_pause` at 1, a received pause code sets `tx_paused` in the next cycle and a received resume code clears it. With `cfg_auto_pause` at 0, `tx_paused` stays 0. If one character matches both codes, it counts as the pause code.
- R5: While `tx_paused` is 1, no FIFO character is popped or loaded. `tx_load` is never asserted while `tx_busy` is 1, so a character in flight always completes.
- R6: When the shifter is idle, a pending control code is loaded (pause code before resume code) ahead of any FIFO character, without popping the FIFO. This happens even while paused.
- R7: With `cfg_auto_throttle` at 1, a FIFO level at or above `cfg_high_mark` queues exactly one pause code and enters the throttled state. No further code is queued until the level is at or below `cfg_low_mark`, which queues exactly one resume code and leaves the state.
- R8: `cmd_send_off` and `cmd_send_on` queue a pause or resume code. A new request cancels the opposite pending one. At most one code is pending, and a simultaneous pause request wins.
- R9: `stat_q` bit layout: bit 7 pause code seen, bit 6 resume code seen, bit 5 a code recognized while bit 7 or 6 was already set, bit 4 a code was stripped, bit 3 `tx_paused`, bit 2 throttled, bit 1 pause code pending, bit 0 resume code pending.
- R10: A `stat_rd` pulse clears bits 7:4 in the next cycle. A recognition in the same cycle as the read still sets its bits, but it does not set bit 5.
- R11: `irq` is 1 exactly when bit 7 or bit 6 of `stat_q` is set. Codes sent because of commands or the throttle never set these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software reset pulse |
| on_char_we | input | 1 | Load `cfg_char` as resume code |
| off_char_we | input | 1 | Load `cfg_char` as pause code |
| cfg_char | input | CHAR_W | Control character value to program |
| cfg_strip | input | 1 | 1 = drop recognized codes from receive data |
| cfg_auto_pause | input | 1 | Enable pausing of the transmitter by received codes |
| cfg_auto_throttle | input | 1 | Enable level-driven pause/resume requests |
| cfg_high_mark | input | LEVEL_W | Level at which a pause code is queued |
| cfg_low_mark | input | LEVEL_W | Level at which a resume code is queued |
| fifo_level | input | LEVEL_W | Receive FIFO fill level |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | CHAR_W | Received character |
| rx_push | output | 1 | Write strobe to the receive FIFO |
| rx_push_data | output | CHAR_W | Data to the receive FIFO |
| cmd_send_on | input | 1 | Host command: queue a resume code |
| cmd_send_off | input | 1 | Host command: queue a pause code |
| tx_busy | input | 1 | Shifter is sending a character |
| tx_fifo_valid | input | 1 | Transmit FIFO holds a character |
| tx_fifo_data | input | CHAR_W | Head of the transmit FIFO |
| tx_fifo_pop | output | 1 | Pop the transmit FIFO head |
| tx_load | output | 1 | Load `tx_load_data` into the shifter |
| tx_load_data | output | CHAR_W | Character handed to the shifter |
| tx_paused | output | 1 | Transmitter held by a received pause code |
| stat_rd | input | 1 | Status read strobe (clears bits 7:4) |
| stat_q | output | 8 | Status byte |
| irq | output | 1 | Interrupt from code recognition |

## Verification
The assertions assume that `tx_busy` reports the shifter truthfully: a character loaded with `tx_load` is accepted only while the shifter is idle. They also assume that `rx_valid` marks single-cycle character strobes. The bench follows both rules. It only lowers `tx_busy` when it wants a load to happen, and it holds the shifter busy while it builds up pending requests. It drives `rx_valid` as one pulse per character. The random phase takes characters from the two control codes and from arbitrary values, and it mixes in random strip settings and status reads. It keeps the shifter idle and the throttle off, so only the receive-side behaviour is scored against the bench model.

// File: rtl/xf_pkg.sv
package xf_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_OFF  = 2'd1,
    SRC_ON   = 2'd2,
    SRC_FIFO = 2'd3
  } xf_src_e;

  typedef struct packed {
    logic off_seen;
    logic on_seen;
    logic again;
    logic dropped;
  } xf_evt_t;
endpackage

// File: rtl/xf_char_match.sv
module xf_char_match #(
  parameter int unsigned CHAR_W = 8,
  parameter logic [CHAR_W-1:0] ON_DEF  = 8'h11,
  parameter logic [CHAR_W-1:0] OFF_DEF = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              on_we,
  input  logic              off_we,
  input  logic [CHAR_W-1:0] cfg_char,
  input  logic              cfg_strip,
  input  logic              cfg_auto_pause,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic [CHAR_W-1:0] on_char,
  output logic [CHAR_W-1:0] off_char,
  output logic              on_hit,
  output logic              off_hit,
  output logic              strip_hit,
  output logic              rx_push,
  output logic              paused
);
  localparam int unsigned NCODE = 2;
  localparam logic [NCODE-1:0][CHAR_W-1:0] DEFV = {OFF_DEF, ON_DEF};

  logic [NCODE-1:0][CHAR_W-1:0] code_q;
  logic [NCODE-1:0]             code_we;
  logic [NCODE-1:0]             match;
  logic                         paused_d;
  logic                         paused_q;

  assign code_we = {off_we, on_we};

  for (genvar gi = 0; gi < NCODE; gi++) begin : g_code
    logic              en;
    logic [CHAR_W-1:0] d;
    always_comb begin
      en = sw_reset | code_we[gi];
      d  = sw_reset ? DEFV[gi] : cfg_char;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q[gi] <= DEFV[gi];
      else if (en) code_q[gi] <= d;
    end
    assign match[gi] = rx_valid && (rx_char == code_q[gi]);
  end

  always_comb begin
    off_hit   = match[1];
    on_hit    = match[0] & ~match[1];
    strip_hit = cfg_strip & (on_hit | off_hit);
    rx_push   = rx_valid & ~strip_hit;
    paused_d  = paused_q;
    if (off_hit)     paused_d = 1'b1;
    else if (on_hit) paused_d = 1'b0;
    if (sw_reset || !cfg_auto_pause) paused_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) paused_q <= 1'b0;
    else        paused_q <= paused_d;
  end

  assign on_char  = code_q[0];
  assign off_char = code_q[1];
  assign paused   = paused_q;
endmodule

// File: rtl/xf_level_watch.sv
module xf_level_watch #(
  parameter int unsigned LEVEL_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_reset,
  input  logic               enable,
  input  logic [LEVEL_W-1:0] level,
  input  logic [LEVEL_W-1:0] high_mark,
  input  logic [LEVEL_W-1:0] low_mark,
  output logic               throttled,
  output logic               req_off,
  output logic               req_on
);
  logic thr_q;
  logic thr_d;

  always_comb begin
    req_off = enable & ~sw_reset & ~thr_q & (level >= high_mark);
    req_on  = enable & ~sw_reset &  thr_q & (level <= low_mark);
    thr_d   = thr_q;
    if (req_off)     thr_d = 1'b1;
    else if (req_on) thr_d = 1'b0;
    if (sw_reset || !enable) thr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= 1'b0;
    else        thr_q <= thr_d;
  end

  assign throttled = thr_q;
endmodule

// File: rtl/xf_tx_arbiter.sv
module xf_tx_arbiter
  import xf_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              cmd_on,
  input  logic              cmd_off,
  input  logic              auto_on,
  input  logic              auto_off,
  input  logic              paused,
  input  logic              tx_busy,
  input  logic              fifo_valid,
  input  logic [CHAR_W-1:0] fifo_data,
  input  logic [CHAR_W-1:0] on_char,
  input  logic [CHAR_W-1:0] off_char,
  output logic              pend_on,
  output logic              pend_off,
  output logic              tx_load,
  output logic [CHAR_W-1:0] tx_load_data,
  output logic              fifo_pop
);
  logic    pon_q, poff_q, pon_d, poff_d;
  logic    new_on, new_off;
  xf_src_e src;

  always_comb begin
    new_off = cmd_off | auto_off;
    new_on  = (cmd_on | auto_on) & ~new_off;
    src     = SRC_NONE;
    if (!tx_busy) begin
      if (poff_q)                    src = SRC_OFF;
      else if (pon_q)                src = SRC_ON;
      else if (fifo_valid && !paused) src = SRC_FIFO;
    end
    poff_d = poff_q & (src != SRC_OFF);
    pon_d  = pon_q  & (src != SRC_ON);
    if (new_off) begin
      poff_d = 1'b1;
      pon_d  = 1'b0;
    end else if (new_on) begin
      pon_d  = 1'b1;
      poff_d = 1'b0;
    end
    if (sw_reset) begin
      poff_d = 1'b0;
      pon_d  = 1'b0;
    end
  end

  always_comb begin
    tx_load      = (src != SRC_NONE);
    fifo_pop     = (src == SRC_FIFO);
    case (src)
      SRC_OFF:  tx_load_data = off_char;
      SRC_ON:   tx_load_data = on_char;
      SRC_FIFO: tx_load_data = fifo_data;
      default:  tx_load_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pon_q  <= 1'b0;
      poff_q <= 1'b0;
    end else begin
      pon_q  <= pon_d;
      poff_q <= poff_d;
    end
  end

  assign pend_on  = pon_q;
  assign pend_off = poff_q;
endmodule

// File: rtl/xf_status.sv
module xf_status
  import xf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_reset,
  input  logic       rd,
  input  logic       on_hit,
  input  logic       off_hit,
  input  logic       strip_hit,
  input  logic       paused,
  input  logic       throttled,
  input  logic       pend_off,
  input  logic       pend_on,
  output logic [7:0] stat_q,
  output logic       irq
);
  xf_evt_t evt_q, evt_d, base;
  logic    any_hit, any_prev;

  always_comb begin
    any_hit  = on_hit | off_hit;
    any_prev = evt_q.off_seen | evt_q.on_seen;
    base     = rd ? '0 : evt_q;
    evt_d.off_seen = base.off_seen | off_hit;
    evt_d.on_seen  = base.on_seen  | on_hit;
    evt_d.again    = base.again    | (any_hit & any_prev & ~rd);
    evt_d.dropped  = base.dropped  | strip_hit;
    if (sw_reset) evt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign stat_q = {evt_q, paused, throttled, pend_off, pend_on};
  assign irq    = evt_q.off_seen | evt_q.on_seen;
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned LEVEL_W = 9,
  parameter logic [CHAR_W-1:0] ON_DEF  = 8'h11,
  parameter logic [CHAR_W-1:0] OFF_DEF = 8'h13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_reset,
  input  logic               on_char_we,
  input  logic               off_char_we,
  input  logic [CHAR_W-1:0]  cfg_char,
  input  logic               cfg_strip,
  input  logic               cfg_auto_pause,
  input  logic               cfg_auto_throttle,
  input  logic [LEVEL_W-1:0] cfg_high_mark,
  input  logic [LEVEL_W-1:0] cfg_low_mark,
  input  logic [LEVEL_W-1:0] fifo_level,
  input  logic               rx_valid,
  input  logic [CHAR_W-1:0]  rx_char,
  output logic               rx_push,
  output logic [CHAR_W-1:0]  rx_push_data,
  input  logic               cmd_send_on,
  input  logic               cmd_send_off,
  input  logic               tx_busy,
  input  logic               tx_fifo_valid,
  input  logic [CHAR_W-1:0]  tx_fifo_data,
  output logic               tx_fifo_pop,
  output logic               tx_load,
  output logic [CHAR_W-1:0]  tx_load_data,
  output logic               tx_paused,
  input  logic               stat_rd,
  output logic [7:0]         stat_q,
  output logic               irq
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [CHAR_W-1:0] on_char, off_char;
  logic              on_hit, off_hit, strip_hit;
  logic              throttled, req_on, req_off;
  logic              pend_on, pend_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  xf_char_match #(.CHAR_W(CHAR_W), .ON_DEF(ON_DEF), .OFF_DEF(OFF_DEF)) u_match (
    .clk(clk), .rst_n(rst_core_n), .sw_reset(sw_reset),
    .on_we(on_char_we), .off_we(off_char_we), .cfg_char(cfg_char),
    .cfg_strip(cfg_strip), .cfg_auto_pause(cfg_auto_pause),
    .rx_valid(rx_valid), .rx_char(rx_char),
    .on_char(on_char), .off_char(off_char),
    .on_hit(on_hit), .off_hit(off_hit), .strip_hit(strip_hit),
    .rx_push(rx_push), .paused(tx_paused)
  );

  xf_level_watch #(.LEVEL_W(LEVEL_W)) u_level (
    .clk(clk), .rst_n(rst_core_n), .sw_reset(sw_reset),
    .enable(cfg_auto_throttle), .level(fifo_level),
    .high_mark(cfg_high_mark), .low_mark(cfg_low_mark),
    .throttled(throttled), .req_off(req_off), .req_on(req_on)
  );

  xf_tx_arbiter #(.CHAR_W(CHAR_W)) u_arb (
    .clk(clk), .rst_n(rst_core_n), .sw_reset(sw_reset),
    .cmd_on(cmd_send_on), .cmd_off(cmd_send_off),
    .auto_on(req_on), .auto_off(req_off),
    .paused(tx_paused), .tx_busy(tx_busy),
    .fifo_valid(tx_fifo_valid), .fifo_data(tx_fifo_data),
    .on_char(on_char), .off_char(off_char),
    .pend_on(pend_on), .pend_off(pend_off),
    .tx_load(tx_load), .tx_load_data(tx_load_data), .fifo_pop(tx_fifo_pop)
  );

  xf_status u_stat (
    .clk(clk), .rst_n(rst_core_n), .sw_reset(sw_reset), .rd(stat_rd),
    .on_hit(on_hit), .off_hit(off_hit), .strip_hit(strip_hit),
    .paused(tx_paused), .throttled(throttled),
    .pend_off(pend_off), .pend_on(pend_on),
    .stat_q(stat_q), .irq(irq)
  );

  assign rx_push_data = rx_char;
endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              sw_reset,
  input logic              cfg_strip,
  input logic              cfg_auto_pause,
  input logic              on_hit,
  input logic              off_hit,
  input logic              rx_push,
  input logic              tx_busy,
  input logic              tx_load,
  input logic              tx_fifo_pop,
  input logic [CHAR_W-1:0] tx_load_data,
  input logic [CHAR_W-1:0] on_char,
  input logic [CHAR_W-1:0] off_char,
  input logic              tx_paused,
  input logic              stat_rd,
  input logic [7:0]        stat_q,
  input logic              irq
);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_load |-> !tx_busy);
  // R5
  pause_block_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_paused |-> !tx_fifo_pop);
  // R4
  pause_set_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (off_hit && cfg_auto_pause && !sw_reset) |=> tx_paused);
  // R3
  strip_drop_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_strip && (on_hit || off_hit)) |-> !rx_push);
  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (stat_rd && !on_hit && !off_hit) |=> (stat_q[7:4] == 4'h0));
  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq) |-> $past(on_hit || off_hit));
  // R8
  pend_single_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(stat_q[1:0]));
  // R6
  insert_code_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_load && !tx_fifo_pop) |-> (tx_load_data == on_char || tx_load_data == off_char));
endmodule

bind xonxoff_flow_ctrl xf_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .sw_reset(sw_reset),
  .cfg_strip(cfg_strip), .cfg_auto_pause(cfg_auto_pause),
  .on_hit(on_hit), .off_hit(off_hit), .rx_push(rx_push),
  .tx_busy(tx_busy), .tx_load(tx_load), .tx_fifo_pop(tx_fifo_pop),
  .tx_load_data(tx_load_data), .on_char(on_char), .off_char(off_char),
  .tx_paused(tx_paused), .stat_rd(stat_rd), .stat_q(stat_q), .irq(irq)
);

// File: tb/tb_xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module tb_xonxoff_flow_ctrl;
  localparam int CW = 8;
  localparam int LW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sw_reset, on_char_we, off_char_we;
  logic [CW-1:0] cfg_char;
  logic          cfg_strip, cfg_auto_pause, cfg_auto_throttle;
  logic [LW-1:0] cfg_high_mark, cfg_low_mark, fifo_level;
  logic          rx_valid;
  logic [CW-1:0] rx_char;
  logic          rx_push;
  logic [CW-1:0] rx_push_data;
  logic          cmd_send_on, cmd_send_off, tx_busy, tx_fifo_valid;
  logic [CW-1:0] tx_fifo_data;
  logic          tx_fifo_pop, tx_load;
  logic [CW-1:0] tx_load_data;
  logic          tx_paused, stat_rd;
  logic [7:0]    stat_q;
  logic          irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  xonxoff_flow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
    .on_char_we(on_char_we), .off_char_we(off_char_we), .cfg_char(cfg_char),
    .cfg_strip(cfg_strip), .cfg_auto_pause(cfg_auto_pause),
    .cfg_auto_throttle(cfg_auto_throttle),
    .cfg_high_mark(cfg_high_mark), .cfg_low_mark(cfg_low_mark),
    .fifo_level(fifo_level), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_push(rx_push), .rx_push_data(rx_push_data),
    .cmd_send_on(cmd_send_on), .cmd_send_off(cmd_send_off),
    .tx_busy(tx_busy), .tx_fifo_valid(tx_fifo_valid), .tx_fifo_data(tx_fifo_data),
    .tx_fifo_pop(tx_fifo_pop), .tx_load(tx_load), .tx_load_data(tx_load_data),
    .tx_paused(tx_paused), .stat_rd(stat_rd), .stat_q(stat_q), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    rx_valid = 1'b0; cmd_send_on = 1'b0; cmd_send_off = 1'b0;
    stat_rd = 1'b0; sw_reset = 1'b0; on_char_we = 1'b0; off_char_we = 1'b0;
  endtask

  function automatic logic is_code(input logic [CW-1:0] c);
    return (c == 8'h11) || (c == 8'h13);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp<%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; sw_reset = 0; on_char_we = 0; off_char_we = 0; cfg_char = '0;
    cfg_strip = 0; cfg_auto_pause = 1; cfg_auto_throttle = 0;
    cfg_high_mark = 9'd200; cfg_low_mark = 9'd50; fifo_level = '0;
    rx_valid = 0; rx_char = '0; cmd_send_on = 0; cmd_send_off = 0;
    tx_busy = 0; tx_fifo_valid = 0; tx_fifo_data = '0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 reset stat", stat_q, 8'h00);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset paused", tx_paused, 0);
    chk("R1 reset load", tx_load, 0);

    // default pause code, transparent
    rx_valid = 1; rx_char = 8'h13;
    #1 chk("R3 transparent push", rx_push, 1);
    chk("R3 push data", rx_push_data, 8'h13);
    step();
    chk("R4 pause set", tx_paused, 1);
    chk("R9 stat after pause", stat_q, 8'h88);
    chk("R11 irq on recog", irq, 1);
    tx_fifo_valid = 1; tx_fifo_data = 8'h41;
    #1 chk("R5 no load paused", tx_load, 0);
    rx_valid = 1; rx_char = 8'h11;
    step();
    chk("R4 pause cleared", tx_paused, 0);
    chk("R9 stat repeat", stat_q, 8'hE0);
    #1 chk("R5 fifo load", tx_load, 1);
    chk("R5 fifo pop", tx_fifo_pop, 1);
    chk("R5 fifo data", tx_load_data, 8'h41);
    tx_fifo_valid = 0; stat_rd = 1;
    step();
    chk("R10 read clear", stat_q, 8'h00);
    chk("R11 irq clear", irq, 0);

    // strip
    cfg_strip = 1; rx_valid = 1; rx_char = 8'h13;
    #1 chk("R3 strip drop", rx_push, 0);
    step();
    chk("R9 stat strip", stat_q, 8'h98);
    stat_rd = 1; rx_valid = 1; rx_char = 8'h11;
    step();
    chk("R10 event during read", stat_q, 8'h50);
    rx_valid = 1; rx_char = 8'h41;
    #1 chk("R3 strip plain char", rx_push, 1);
    stat_rd = 1;
    step();
    // R2 reprogram resume code
    on_char_we = 1; cfg_char = 8'h55;
    step();
    rx_valid = 1; rx_char = 8'h11;
    #1 chk("R2 old code ignored", rx_push, 1);
    step();
    rx_valid = 1; rx_char = 8'h55;
    #1 chk("R2 new code stripped", rx_push, 0);
    step();
    chk("R2 new code stat", stat_q, 8'h50);
    sw_reset = 1;
    step();
    chk("R1 sw reset stat", stat_q, 8'h00);
    rx_valid = 1; rx_char = 8'h11;
    #1 chk("R1 default code back", rx_push, 0);
    step();
    stat_rd = 1;
    step();
    // R4 auto pause disabled
    cfg_auto_pause = 0; rx_valid = 1; rx_char = 8'h13;
    step();
    chk("R4 no pause when disabled", tx_paused, 0);
    chk("R11 irq still set", irq, 1);
    stat_rd = 1; cfg_auto_pause = 1; cfg_strip = 0;
    step();

    // R6 command insert ahead of fifo
    tx_busy = 1; tx_fifo_valid = 1; tx_fifo_data = 8'h41; cmd_send_off = 1;
    #1 chk("R5 no load busy", tx_load, 0);
    step();
    chk("R8 off pending", stat_q, 8'h02);
    tx_busy = 0;
    #1 chk("R6 insert load", tx_load, 1);
    chk("R6 insert data", tx_load_data, 8'h13);
    chk("R6 insert no pop", tx_fifo_pop, 0);
    step();
    #1 chk("R6 fifo after insert", tx_fifo_pop, 1);
    chk("R11 cmd no irq", irq, 0);
    tx_fifo_valid = 0; tx_busy = 1; cmd_send_off = 1;
    step();
    cmd_send_on = 1;
    step();
    chk("R8 on cancels off", stat_q[1:0], 2'b01);
    cmd_send_on = 1; cmd_send_off = 1;
    step();
    chk("R8 off wins", stat_q[1:0], 2'b10);
    tx_busy = 0;
    #1 chk("R8 off sent", tx_load_data, 8'h13);
    step();
    chk("R8 pending done", stat_q, 8'h00);

    // R6 insert while paused
    rx_valid = 1; rx_char = 8'h13;
    step();
    tx_fifo_valid = 1; cmd_send_on = 1;
    #1 chk("R5 paused no load", tx_load, 0);
    step();
    #1 chk("R6 insert while paused", tx_load, 1);
    chk("R6 insert on data", tx_load_data, 8'h11);
    chk("R6 insert paused no pop", tx_fifo_pop, 0);
    step();
    #1 chk("R5 paused after insert", tx_load, 0);
    rx_valid = 1; rx_char = 8'h11;
    step();
    #1 chk("R5 resume pop", tx_fifo_pop, 1);
    tx_fifo_valid = 0; stat_rd = 1;
    step();

    // R7 throttle hysteresis
    tx_busy = 1; cfg_auto_throttle = 1; cfg_high_mark = 9'd8; cfg_low_mark = 9'd3;
    fifo_level = 9'd7;
    step();
    chk("R7 below high", stat_q, 8'h00);
    fifo_level = 9'd8;
    step();
    chk("R7 throttle on", stat_q, 8'h06);
    tx_busy = 0; fifo_level = 9'd12;
    #1 chk("R7 pause code sent", tx_load_data, 8'h13);
    step();
    chk("R7 no repeat", stat_q, 8'h04);
    #1 chk("R7 no second load", tx_load, 0);
    fifo_level = 9'd4;
    step();
    chk("R7 hold above low", stat_q, 8'h04);
    fifo_level = 9'd3;
    step();
    chk("R7 resume queued", stat_q, 8'h01);
    #1 chk("R7 resume code sent", tx_load_data, 8'h11);
    step();
    chk("R7 idle after", stat_q, 8'h00);
    chk("R11 throttle no irq", irq, 0);
    cfg_auto_throttle = 0; fifo_level = '0;
    step();

    // random receive phase
    begin
      logic m_p, m7, m6, m5, m4;
      m_p = 0; m7 = 0; m6 = 0; m5 = 0; m4 = 0;
      for (int i = 0; i < 400; i++) begin
        logic [CW-1:0] c;
        logic v, s, r, hon, hoff, prev;
        int k;
        k = $urandom_range(0, 3);
        c = (k == 0) ? 8'h11 : (k == 1) ? 8'h13 : 8'($urandom);
        v = ($urandom_range(0, 3) != 0);
        s = 1'($urandom);
        r = ($urandom_range(0, 4) == 0);
        rx_valid = v; rx_char = c; cfg_strip = s; stat_rd = r;
        #1 chk("R3 random push", rx_push, v && !(s && is_code(c)));
        hoff = v && (c == 8'h13);
        hon  = v && (c == 8'h11);
        prev = m7 | m6;
        if (r) begin m7 = 0; m6 = 0; m5 = 0; m4 = 0; end
        m7 = m7 | hoff;
        m6 = m6 | hon;
        m5 = m5 | ((hon | hoff) & prev & !r);
        m4 = m4 | (s & (hon | hoff));
        if (hoff) m_p = 1; else if (hon) m_p = 0;
        step();
        chk("R4 random pause", tx_paused, m_p);
        chk("R9 random stat", stat_q[7:4], {m7, m6, m5, m4});
        chk("R11 random irq", irq, m7 | m6);
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule